// File: doc/BRIEF.md
# Strobe-Acknowledge Processor Bus Slave

This block is the target side of a simple asynchronous processor bus. A host presents an enable, a write select, a 16-bit address and 16-bit write data, and then pulls an active-low strobe. The block brings the strobe into its own clock domain through one flop and treats each falling edge as the start of an access. It then waits a fixed number of clocks, chosen by the kind of access, and drives an active-low acknowledge. When the host lifts the strobe, the block stops driving the acknowledge. The tri-state pad is modelled by an output-enable beside the acknowledge level.

Address bit 15 selects between two spaces. When it is 0, the access goes to a bank of eight 16-bit registers. When it is 1, the access goes to a 256-word, 32-bit memory, and it takes two bus accesses to move one word. A first/second phase toggle decides which half each memory access carries. The two halves of a memory access have different latencies, and they differ again between reads and writes.

Top module: `strobe_ack_slave`

## Requirements
- R1: After reset, ack_oe and bus_rdata_oe are 0, ack_n is 1, every register reads back as 0, and the memory phase is "first".
- R2: A register write (bus_wr=1, address bit 15 = 0) writes bus_wdata into register bus_addr[2:0]. It is acknowledged more than 2 and at most 3 clock periods after the strobe falls.
- R3: A register read (bus_wr=0, address bit 15 = 0) is acknowledged more than 4 and at most 5 periods after the strobe falls. While acknowledged, bus_rdata_oe is 1 and bus_rdata holds register bus_addr[2:0], stable.
- R4: A memory write takes two accesses. The first carries bits 15:0 and is acknowledged after more than 3 and at most 4 periods. The second carries bits 31:16, is acknowledged after more than 7 and at most 8 periods, and commits the full word to memory index bus_addr[7:0].
- R5: A memory read takes two accesses. The first is acknowledged after more than 9 and at most 10 periods and returns bits 15:0 of word bus_addr[7:0]. The second is acknowledged after more than 3 and at most 4 periods and returns bits 31:16 of the same word.
- R6: Address bit 15 alone selects the space. A register access never alters memory contents, and a memory access never alters registers.
- R7: Once acknowledged, ack_oe stays 1 while the strobe stays low. It drops more than 1 and at most 2 periods after the strobe rises, and bus_rdata_oe drops with it.
- R8: A strobe fall while bus_en is 0 produces no acknowledge and changes no state.
- R9: The memory phase flips after every completed memory access and returns to "first" after any register access.
- R10: Strobe edges that occur while an access is still pending do not restart it or shift its acknowledge time.
- R11: ack_n is 0 exactly when ack_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Chip enable from host, active high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Address; bit 15 selects memory |
| bus_wdata | input | 16 | Write data |
| bus_stb_n | input | 1 | Asynchronous strobe, active low |
| bus_rdata | output | 16 | Read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Acknowledge level, active low |
| ack_oe | output | 1 | Acknowledge drive enable (0 = high impedance) |

## Verification
The bench places the strobe edges at several different offsets within the clock period. For every access, it measures the time from the strobe edge to the acknowledge edge and checks that it falls inside the one-period window for that access kind. An off-by-one counter load would land one period outside the window.

Each word is written as two halves and read back as two halves. A swapped half, a lost holding value, or a commit made on the first half would each return the wrong 16 bits.

The bench also places a register access between two memory halves. A phase toggle that is not cleared by that register access would give the next memory write a 7-cycle latency instead of 3.

Finally, the bench pulses the strobe with enable low, and glitches the strobe while an access is pending. A design that reacts to either would acknowledge when it should not, or would restart its count and miss the window.

// File: rtl/strobe_ack_pkg.sv
package strobe_ack_pkg;

    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 16;
    localparam int SPACE_BIT   = 15;
    localparam int CNT_W       = 4;

    localparam int LAT_REG_WR  = 2;
    localparam int LAT_REG_RD  = 4;
    localparam int LAT_MWR_LO  = 3;
    localparam int LAT_MWR_HI  = 7;
    localparam int LAT_MRD_LO  = 9;
    localparam int LAT_MRD_HI  = 3;

    typedef enum logic [2:0] {
        K_REG_WR,
        K_REG_RD,
        K_MWR_LO,
        K_MWR_HI,
        K_MRD_LO,
        K_MRD_HI
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } req_t;

    function automatic kind_e classify(input logic to_mem, input logic is_wr,
                                       input logic second);
        kind_e k;
        if (!to_mem)     k = is_wr ? K_REG_WR : K_REG_RD;
        else if (is_wr)  k = second ? K_MWR_HI : K_MWR_LO;
        else             k = second ? K_MRD_HI : K_MRD_LO;
        return k;
    endfunction

    // counter preload: the start and acknowledge registers absorb two cycles
    function automatic logic [CNT_W-1:0] preload(input kind_e k);
        int lat;
        case (k)
            K_REG_WR: lat = LAT_REG_WR;
            K_REG_RD: lat = LAT_REG_RD;
            K_MWR_LO: lat = LAT_MWR_LO;
            K_MWR_HI: lat = LAT_MWR_HI;
            K_MRD_LO: lat = LAT_MRD_LO;
            default:  lat = LAT_MRD_HI;
        endcase
        return CNT_W'(lat - 2);
    endfunction

    function automatic logic is_mem(input kind_e k);
        return (k == K_MWR_LO) || (k == K_MWR_HI) || (k == K_MRD_LO) || (k == K_MRD_HI);
    endfunction

    function automatic logic is_read(input kind_e k);
        return (k == K_REG_RD) || (k == K_MRD_LO) || (k == K_MRD_HI);
    endfunction

endpackage

// File: rtl/stb_sync.sv
module stb_sync (
    input  logic clk,
    input  logic rst,
    input  logic stb_n_async,
    output logic stb_high,
    output logic stb_fall
);
    logic s_q;
    logic d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= 1'b1;
            d_q <= 1'b1;
        end else begin
            s_q <= stb_n_async;
            d_q <= s_q;
        end
    end

    assign stb_high = s_q;
    assign stb_fall = d_q & ~s_q;
endmodule

// File: rtl/lat_ctrl.sv
module lat_ctrl import strobe_ack_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_fall,
    input  logic             stb_high,
    input  logic             enable,
    input  logic [CNT_W-1:0] load,
    output logic             start,
    output logic             done,
    output logic             release_now,
    output logic             ack_oe,
    output logic             ack_n
);
    phase_e           st_q;
    logic [CNT_W-1:0] cnt_q;

    assign start       = (st_q == PH_IDLE) && stb_fall && enable;
    assign done        = (st_q == PH_WAIT) && (cnt_q == '0);
    assign release_now = (st_q == PH_HOLD) && stb_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            ack_oe <= 1'b0;
            ack_n  <= 1'b1;
        end else begin
            case (st_q)
                PH_IDLE: if (start) begin
                    cnt_q <= load;
                    st_q  <= PH_WAIT;
                end
                PH_WAIT: if (done) begin
                    st_q   <= PH_HOLD;
                    ack_oe <= 1'b1;
                    ack_n  <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_HOLD: if (release_now) begin
                    st_q   <= PH_IDLE;
                    ack_oe <= 1'b0;
                    ack_n  <= 1'b1;
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank import strobe_ack_pkg::*; #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                           regs[g] <= '0;
            else if (wr_en && idx == IW'(g))   regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx];
endmodule

// File: rtl/mem_buf.sv
module mem_buf import strobe_ack_pkg::*; #(
    parameter int DEPTH = 256,
    localparam int IW = $clog2(DEPTH),
    localparam int WW = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  kind_e             kind,
    input  logic [IW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              second
);
    logic [WW-1:0]     mem [DEPTH];
    logic [DATA_W-1:0] hold_q;
    logic              ph_q;
    logic [WW-1:0]     word;

    assign word   = mem[idx];
    assign rdata  = (kind == K_MRD_HI) ? hold_q : word[DATA_W-1:0];
    assign second = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 1'b0;
            hold_q <= '0;
        end else if (done) begin
            ph_q <= is_mem(kind) ? ~ph_q : 1'b0;
            case (kind)
                K_MWR_LO: hold_q <= wdata;
                K_MRD_LO: hold_q <= word[WW-1:DATA_W];
                default:  hold_q <= hold_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (done && kind == K_MWR_HI) mem[idx] <= {wdata, hold_q};
    end
endmodule

// File: rtl/strobe_ack_slave.sv
module strobe_ack_slave import strobe_ack_pkg::*; #(
    parameter int REG_N = 8,
    parameter int MEM_N = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_stb_n,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              ack_n,
    output logic              ack_oe
);
    localparam int RIW = $clog2(REG_N);
    localparam int MIW = $clog2(MEM_N);

    logic              stb_high, stb_fall;
    logic              start, done, release_now;
    logic              second;
    kind_e             new_kind;
    req_t              req_q;
    logic [DATA_W-1:0] reg_rd, mem_rd;
    logic              addr_unused;

    assign new_kind    = classify(bus_addr[SPACE_BIT], bus_wr, second);
    assign addr_unused = ^{req_q.addr[ADDR_W-1:MIW], req_q.addr[MIW-1:RIW]};

    stb_sync u_sync (
        .clk(clk), .rst(rst), .stb_n_async(bus_stb_n),
        .stb_high(stb_high), .stb_fall(stb_fall)
    );

    lat_ctrl u_lat (
        .clk(clk), .rst(rst), .stb_fall(stb_fall), .stb_high(stb_high),
        .enable(bus_en), .load(preload(new_kind)),
        .start(start), .done(done), .release_now(release_now),
        .ack_oe(ack_oe), .ack_n(ack_n)
    );

    always_ff @(posedge clk) begin
        if (rst)        req_q <= '0;
        else if (start) req_q <= '{kind: new_kind, addr: bus_addr, data: bus_wdata};
    end

    reg_bank #(.N(REG_N)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(done && req_q.kind == K_REG_WR),
        .idx(req_q.addr[RIW-1:0]), .wdata(req_q.data), .rdata(reg_rd)
    );

    mem_buf #(.DEPTH(MEM_N)) u_mem (
        .clk(clk), .rst(rst), .done(done), .kind(req_q.kind),
        .idx(req_q.addr[MIW-1:0]), .wdata(req_q.data),
        .rdata(mem_rd), .second(second)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            bus_rdata_oe <= 1'b0;
        end else if (done && is_read(req_q.kind)) begin
            bus_rdata    <= (req_q.kind == K_REG_RD) ? reg_rd : mem_rd;
            bus_rdata_oe <= 1'b1;
        end else if (release_now) begin
            bus_rdata_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/strobe_ack_slave_chk.sv
module strobe_ack_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_stb_n,
    input logic [15:0] bus_rdata,
    input logic        bus_rdata_oe,
    input logic        ack_n,
    input logic        ack_oe
);
    AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ack_oe == !ack_n);                                                   // R11

    AST_RDATA_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> ack_oe);                                            // R3

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata_oe && $past(bus_rdata_oe)) |-> $stable(bus_rdata));       // R3

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && !bus_stb_n && $past(!bus_stb_n)) |=> ack_oe);             // R7

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && bus_stb_n) |=> ##1 !ack_oe);                              // R7
endmodule

bind strobe_ack_slave strobe_ack_slave_chk u_chk (
    .clk(clk), .rst(rst), .bus_stb_n(bus_stb_n), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .ack_n(ack_n), .ack_oe(ack_oe)
);

// File: tb/strobe_ack_slave_test.sv
`timescale 1ns/1ps
module strobe_ack_slave_test;
    localparam real T = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_stb_n = 1'b1;
    logic [15:0] bus_rdata;
    logic        bus_rdata_oe;
    logic        ack_n;
    logic        ack_oe;

    int vectors = 0;
    int errors  = 0;
    bit running = 1'b1;

    always #4 clk = ~clk;

    strobe_ack_slave uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stb_n(bus_stb_n),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .ack_n(ack_n), .ack_oe(ack_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of the acknowledge pair and read-data enable (R11)
    always @(negedge clk) begin
        if (!rst && running) begin
            check(ack_n == !ack_oe, "R11", "ack_n vs ack_oe", ack_n, !ack_oe);
            if (bus_rdata_oe)
                check(ack_oe, "R3", "rdata_oe without ack", ack_oe, 1);
        end
    end

    // one bus access with the strobe falling ph ns after a rising edge
    task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                          input int lat, input logic rd_chk, input logic [15:0] exp,
                          input int ph, input logic glitch, input string req);
        realtime t0, ta, t1, tr;
        bit seen, gone;
        seen = 0; gone = 0; ta = 0; tr = 0;
        @(posedge clk); #1;
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        if (ph > 1) #(ph - 1);
        t0 = $realtime;
        bus_stb_n = 1'b0;
        if (glitch) begin   // R10: strobe bounce while the access is pending
            @(posedge clk); @(posedge clk); #2 bus_stb_n = 1'b1;
            @(posedge clk); #2 bus_stb_n = 1'b0;
        end
        for (int i = 0; i < 24 && !seen; i++) begin
            @(posedge clk); #1;
            if (ack_oe) begin seen = 1; ta = $realtime - 1; end
        end
        check(seen, req, "acknowledge seen", seen, 1);
        check(seen && (ta - t0 > lat * T) && (ta - t0 <= (lat + 1) * T), req,
              "ack latency ps", longint'((ta - t0) * 1000), longint'(lat * T * 1000));
        check(ack_n == 1'b0, "R11", "ack_n low while driven", ack_n, 0);
        if (rd_chk) begin
            check(bus_rdata_oe, req, "rdata_oe", bus_rdata_oe, 1);
            check(bus_rdata == exp, req, "read data", bus_rdata, exp);
        end
        @(posedge clk); #3;
        check(ack_oe, "R7", "ack held while strobe low", ack_oe, 1);
        t1 = $realtime;
        bus_stb_n = 1'b1;
        for (int i = 0; i < 6 && !gone; i++) begin
            @(posedge clk); #1;
            if (!ack_oe) begin gone = 1; tr = $realtime - 1; end
        end
        check(gone && (tr - t1 > T) && (tr - t1 <= 2 * T), "R7", "release latency ps",
              longint'((tr - t1) * 1000), longint'(2 * T * 1000));
        check(ack_n && !bus_rdata_oe, "R7", "idle after release",
              {ack_n, bus_rdata_oe}, 2'b10);
        bus_en = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        bit any;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        check(!ack_oe && ack_n && !bus_rdata_oe, "R1", "reset outputs",
              {ack_oe, ack_n, bus_rdata_oe}, 3'b010);
        access(0, 16'h0005, 0, 4, 1, 16'h0000, 2, 0, "R1");

        // register writes then reads (R2, R3)
        access(1, 16'h0003, 16'hA5C3, 2, 0, 0, 1, 0, "R2");
        access(1, 16'h0007, 16'h1234, 2, 0, 0, 5, 0, "R2");
        access(0, 16'h0003, 0, 4, 1, 16'hA5C3, 3, 0, "R3");
        access(0, 16'h0007, 0, 4, 1, 16'h1234, 7, 0, "R3");

        // memory writes in two halves (R4), reads in two halves (R5)
        access(1, 16'h8012, 16'hBEEF, 3, 0, 0, 2, 0, "R4");
        access(1, 16'h8012, 16'hDEAD, 7, 0, 0, 6, 0, "R4");
        access(1, 16'h80FF, 16'h0001, 3, 0, 0, 4, 0, "R4");
        access(1, 16'h80FF, 16'h8000, 7, 0, 0, 1, 0, "R4");
        access(0, 16'h8012, 0, 9, 1, 16'hBEEF, 5, 0, "R5");
        access(0, 16'h8012, 0, 3, 1, 16'hDEAD, 3, 0, "R5");
        access(0, 16'h80FF, 0, 9, 1, 16'h0001, 7, 0, "R5");
        access(0, 16'h80FF, 0, 3, 1, 16'h8000, 2, 0, "R5");

        // space select by bit 15 only (R6): register index 2 via two aliases
        access(1, 16'h0012, 16'h5555, 2, 0, 0, 3, 0, "R6");
        access(0, 16'h8012, 0, 9, 1, 16'hBEEF, 6, 0, "R6");
        access(0, 16'h8012, 0, 3, 1, 16'hDEAD, 1, 0, "R6");
        access(0, 16'h000A, 0, 4, 1, 16'h5555, 4, 0, "R6");

        // phase reset by a register access (R9)
        access(1, 16'h8020, 16'h1111, 3, 0, 0, 2, 0, "R9");
        access(0, 16'h0003, 0, 4, 1, 16'hA5C3, 5, 0, "R9");
        access(1, 16'h8020, 16'h2222, 3, 0, 0, 7, 0, "R9");
        access(1, 16'h8020, 16'h3333, 7, 0, 0, 3, 0, "R9");
        access(0, 16'h8020, 0, 9, 1, 16'h2222, 4, 0, "R9");
        access(0, 16'h8020, 0, 3, 1, 16'h3333, 6, 0, "R9");

        // enable low: strobe ignored (R8)
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 16'h0003; bus_wdata = 16'hFFFF;
        #2 bus_stb_n = 1'b0;
        any = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1;
            if (ack_oe) any = 1;
        end
        check(!any, "R8", "no ack with enable low", any, 0);
        bus_stb_n = 1'b1;
        repeat (3) @(posedge clk);
        access(0, 16'h0003, 0, 4, 1, 16'hA5C3, 2, 0, "R8");

        // strobe bounce during a pending access (R10)
        access(0, 16'h0007, 0, 4, 1, 16'h1234, 3, 1, "R10");
        access(1, 16'h8040, 16'hCAFE, 3, 0, 0, 5, 1, "R10");
        access(1, 16'h8040, 16'hF00D, 7, 0, 0, 1, 1, "R10");
        access(0, 16'h8040, 0, 9, 1, 16'hCAFE, 6, 0, "R10");
        access(0, 16'h8040, 0, 3, 1, 16'hF00D, 2, 0, "R10");

        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule